// File: doc/BRIEF.md
# ARINC 429 Receive Channel with Label Acceptance

This block is one receive channel for a two-wire avionics serial bus. It takes the line pair after it has been turned into logic levels: a HI level, a LO level, or neither, which is the null state. Each bit is a return-to-zero pulse. The block recovers the bits, frames them into 32-bit words and decides which words to keep. A word that passes framing is kept if label acceptance is off. If acceptance is on, the word is kept only when its 8-bit label matches one of up to 16 programmed labels.

Kept words enter a 32-deep queue. The host empties the queue over a 16-bit path, taking each word in two reads: the low half first, then the high half. The bit time can be set per channel to a fast rate or a slow rate. The top bit of each word can be kept as data, or it can be replaced by the result of the parity check.

Top module: `a429_rx_filter`

## Requirements
- R1: A bit begins when the line leaves the null state with only one level asserted: HI gives a 1 and LO gives a 0. The first bit received is stored in word bit 0 and the 32nd in bit 31. The label is word bits 7:0.
- R2: A word is taken only if exactly 32 bit starts arrive and then no bit starts for 4 bit times after the last one. A burst of 31 bits or of 33 bits is discarded.
- R3: A bit that starts 2 or more bit times after the previous bit start discards the partial word and becomes bit 0 of a new word.
- R4: With `rate_sel`=0 a bit time is FAST_BT clocks (8 by default). With `rate_sel`=1 it is SLOW_BT clocks (64 by default).
- R5: With `filt_en`=0 every framed word is queued. With `filt_en`=1 a word is queued only if bits 7:0 equal a programmed entry. A pulse on `lbl_we` programs entry `lbl_idx` with `lbl_val`. Reset leaves no entry programmed.
- R6: With `par_mode`=1 the queued bit 31 is 1 when the 32 received bits hold an even number of ones (parity error) and 0 when they hold an odd number. With `par_mode`=0 the word is queued as received.
- R7: `rd_data` presents bits 15:0 of the oldest word. A `rd_strobe` then switches it to bits 31:16. A second strobe removes the word. Words leave in arrival order, and a strobe while the queue is empty has no effect.
- R8: `data_ready` is high while at least one word is queued. It falls after the high half of the last word is read. `fifo_half` is high at 16 or more words and `fifo_full` at 32 words.
- R9: A word accepted while the queue is full is dropped, and the queued words are left unchanged.
- R10: After reset, `data_ready`, `fifo_half` and `fifo_full` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 1 | 0 selects the fast bit time, 1 the slow bit time |
| filt_en | input | 1 | Enables label acceptance |
| par_mode | input | 1 | Replaces bit 31 with the parity result |
| lbl_we | input | 1 | Write strobe for the label table |
| lbl_idx | input | 4 | Label table entry to write |
| lbl_val | input | 8 | Label value to write |
| line_hi | input | 1 | Digitized HI level of the line |
| line_lo | input | 1 | Digitized LO level of the line |
| rd_strobe | input | 1 | Host read of one 16-bit half |
| rd_data | output | 16 | Half of the oldest queued word |
| data_ready | output | 1 | At least one word is queued |
| fifo_full | output | 1 | Queue holds 32 words |
| fifo_half | output | 1 | Queue holds at least 16 words |

## Verification
A framing counter that is off by one shows up within one word time: `data_ready` fails to rise, or a 31-bit or 33-bit burst is queued. A wrong bit position shows up in the two halves read back. A fault in the label table or the parity path shows up when the same word is read back, as a missing word or a wrong bit 31. Faults in the queue pointers or the half-select show up at the next read as data out of order, a word missing or repeated, or `data_ready` falling after the low half. Miscounted occupancy appears on `fifo_half` or `fifo_full` at the 16th or 32nd write.

// File: rtl/a429_pkg.sv
package a429_pkg;

    typedef logic [31:0] word_t;
    typedef logic [7:0]  label_t;

    typedef struct packed {
        logic  valid;
        word_t data;
    } rx_word_t;

    function automatic label_t label_of(input word_t w);
        return w[7:0];
    endfunction

    // Odd count of ones is good parity; bit 31 flags an even count.
    function automatic word_t tag_parity(input word_t w, input logic par_on);
        return par_on ? {~(^w), w[30:0]} : w;
    endfunction

endpackage

// File: rtl/a429_bit_rx.sv
module a429_bit_rx
    import a429_pkg::*;
#(
    parameter int FAST_BT = 8,
    parameter int SLOW_BT = 64
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     rate_sel,
    input  logic     line_hi,
    input  logic     line_lo,
    output rx_word_t rx_out
);
    localparam int TW = $clog2(4 * SLOW_BT + 1);

    logic          hi_q, lo_q, act_q;
    logic [TW-1:0] timer;
    logic [5:0]    cnt;
    word_t         shreg;
    logic          start;
    logic [TW-1:0] end_lim, restart_lim;

    always_comb begin
        start       = (hi_q ^ lo_q) && !act_q;
        end_lim     = rate_sel ? TW'(4 * SLOW_BT - 1) : TW'(4 * FAST_BT - 1);
        restart_lim = rate_sel ? TW'(2 * SLOW_BT) : TW'(2 * FAST_BT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q   <= 1'b0;
            lo_q   <= 1'b0;
            act_q  <= 1'b0;
            timer  <= '0;
            cnt    <= '0;
            shreg  <= '0;
            rx_out <= '0;
        end else begin
            hi_q         <= line_hi;
            lo_q         <= line_lo;
            act_q        <= hi_q | lo_q;
            rx_out.valid <= 1'b0;
            if (start) begin
                timer <= '0;
                if (cnt != 6'd0 && timer >= restart_lim) begin
                    shreg <= {31'b0, hi_q};
                    cnt   <= 6'd1;
                end else if (cnt >= 6'd32) begin
                    cnt <= 6'd33;
                end else begin
                    shreg[cnt[4:0]] <= hi_q;
                    cnt             <= cnt + 6'd1;
                end
            end else begin
                if (timer != '1) timer <= timer + 1'b1;
                if (cnt != 6'd0 && timer == end_lim) begin
                    cnt <= 6'd0;
                    if (cnt == 6'd32) begin
                        rx_out.valid <= 1'b1;
                        rx_out.data  <= shreg;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/a429_label_filter.sv
module a429_label_filter
    import a429_pkg::*;
#(
    parameter int N_LBL = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     filt_en,
    input  logic                     par_mode,
    input  logic                     lbl_we,
    input  logic [$clog2(N_LBL)-1:0] lbl_idx,
    input  label_t                   lbl_val,
    input  rx_word_t                 in_word,
    output rx_word_t                 out_word
);
    label_t           table_q [N_LBL];
    logic [N_LBL-1:0] used_q;
    logic [N_LBL-1:0] hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            used_q <= '0;
            for (int i = 0; i < N_LBL; i++) table_q[i] <= '0;
        end else if (lbl_we) begin
            table_q[lbl_idx] <= lbl_val;
            used_q[lbl_idx]  <= 1'b1;
        end
    end

    for (genvar g = 0; g < N_LBL; g++) begin : g_cmp
        assign hit[g] = used_q[g] && (table_q[g] == label_of(in_word.data));
    end

    always_comb begin
        out_word.valid = in_word.valid && (!filt_en || (|hit));
        out_word.data  = tag_parity(in_word.data, par_mode);
    end
endmodule

// File: rtl/a429_word_fifo.sv
module a429_word_fifo
    import a429_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  word_t       wr_data,
    input  logic        rd_strobe,
    output logic [15:0] rd_data,
    output logic        ready,
    output logic        full,
    output logic        half
);
    localparam int AW = $clog2(DEPTH);

    word_t       mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count;
    logic          hsel;
    logic          push, pop;

    always_comb begin
        ready   = count != '0;
        full    = count == (AW+1)'(DEPTH);
        half    = count >= (AW+1)'(DEPTH / 2);
        push    = wr_en && !full;
        pop     = rd_strobe && ready && hsel;
        rd_data = hsel ? mem[rd_ptr][31:16] : mem[rd_ptr][15:0];
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            hsel   <= 1'b0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            if (rd_strobe && ready) hsel <= !hsel;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/a429_rx_filter.sv
module a429_rx_filter
    import a429_pkg::*;
#(
    parameter int FAST_BT = 8,
    parameter int SLOW_BT = 64,
    parameter int N_LBL   = 16,
    parameter int DEPTH   = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rate_sel,
    input  logic        filt_en,
    input  logic        par_mode,
    input  logic        lbl_we,
    input  logic [3:0]  lbl_idx,
    input  logic [7:0]  lbl_val,
    input  logic        line_hi,
    input  logic        line_lo,
    input  logic        rd_strobe,
    output logic [15:0] rd_data,
    output logic        data_ready,
    output logic        fifo_full,
    output logic        fifo_half
);
    rx_word_t framed, kept;

    a429_bit_rx #(.FAST_BT(FAST_BT), .SLOW_BT(SLOW_BT)) u_bits (
        .clk(clk), .rst(rst), .rate_sel(rate_sel),
        .line_hi(line_hi), .line_lo(line_lo), .rx_out(framed)
    );

    a429_label_filter #(.N_LBL(N_LBL)) u_filt (
        .clk(clk), .rst(rst), .filt_en(filt_en), .par_mode(par_mode),
        .lbl_we(lbl_we), .lbl_idx(lbl_idx[$clog2(N_LBL)-1:0]), .lbl_val(lbl_val),
        .in_word(framed), .out_word(kept)
    );

    a429_word_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .wr_en(kept.valid), .wr_data(kept.data),
        .rd_strobe(rd_strobe), .rd_data(rd_data), .ready(data_ready),
        .full(fifo_full), .half(fifo_half)
    );
endmodule

// File: rtl/a429_rx_filter_chk.sv
module a429_rx_filter_chk (
    input logic        clk,
    input logic        rst,
    input logic        rd_strobe,
    input logic [15:0] rd_data,
    input logic        data_ready,
    input logic        fifo_full,
    input logic        fifo_half
);
    logic hsel;

    always_ff @(posedge clk) begin
        if (rst) hsel <= 1'b0;
        else if (rd_strobe && data_ready) hsel <= !hsel;
    end

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        fifo_full && !rd_strobe |=> fifo_full); // R9
    AST_EMPTY_FLAGS: assert property (@(posedge clk) disable iff (rst)
        !data_ready |-> !fifo_half && !fifo_full); // R8
    AST_FULL_HALF: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> fifo_half); // R8
    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        data_ready && !rd_strobe |=> data_ready); // R8
    AST_LOW_HALF_KEEPS: assert property (@(posedge clk) disable iff (rst)
        rd_strobe && data_ready && !hsel |=> data_ready); // R7
    AST_RDDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        data_ready && !rd_strobe |=> $stable(rd_data)); // R7
endmodule

bind a429_rx_filter a429_rx_filter_chk u_chk (
    .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .rd_data(rd_data),
    .data_ready(data_ready), .fifo_full(fifo_full), .fifo_half(fifo_half)
);

// File: tb/a429_rx_filter_test.sv
module a429_rx_filter_test;
    localparam int CLK_PERIOD = 10;
    localparam int FAST = 8;
    localparam int SLOW = 64;
    localparam int NV = 8;
    // {par_mode, expect_kept, word}
    localparam logic [33:0] VEC [NV] = '{
        {1'b0, 1'b1, 32'h1234_5631},
        {1'b0, 1'b0, 32'hDEAD_BE55},
        {1'b1, 1'b1, 32'h8000_00A7},
        {1'b1, 1'b1, 32'h0000_0102},
        {1'b1, 1'b1, 32'h8000_0702},
        {1'b0, 1'b0, 32'h0000_00A6},
        {1'b0, 1'b1, 32'hFFFF_FF02},
        {1'b0, 1'b0, 32'h0000_0000}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rate_sel = 1'b0, filt_en = 1'b0, par_mode = 1'b0;
    logic lbl_we = 1'b0;
    logic [3:0] lbl_idx = '0;
    logic [7:0] lbl_val = '0;
    logic line_hi = 1'b0, line_lo = 1'b0, rd_strobe = 1'b0;
    logic [15:0] rd_data;
    logic data_ready, fifo_full, fifo_half;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    a429_rx_filter uut (
        .clk(clk), .rst(rst), .rate_sel(rate_sel), .filt_en(filt_en),
        .par_mode(par_mode), .lbl_we(lbl_we), .lbl_idx(lbl_idx), .lbl_val(lbl_val),
        .line_hi(line_hi), .line_lo(line_lo), .rd_strobe(rd_strobe),
        .rd_data(rd_data), .data_ready(data_ready), .fifo_full(fifo_full),
        .fifo_half(fifo_half)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_word(input logic [31:0] w, input logic p);
        int ones = 0;
        for (int i = 0; i < 32; i++) ones += int'(w[i]);
        if (!p) return w;
        return {(ones % 2 == 0) ? 1'b1 : 1'b0, w[30:0]};
    endfunction

    task automatic send_bits(input logic [31:0] w, input int n, input int bt);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            line_hi = (i < 32) ? w[i] : 1'b0;
            line_lo = (i < 32) ? !w[i] : 1'b1;
            repeat (bt/2) @(negedge clk);
            line_hi = 1'b0;
            line_lo = 1'b0;
            repeat (bt/2 - 1) @(negedge clk);
        end
    endtask

    task automatic gap(input int bt);
        repeat (4*bt + 8) @(negedge clk);
    endtask

    task automatic send_word(input logic [31:0] w, input int n, input int bt);
        send_bits(w, n, bt);
        gap(bt);
    endtask

    task automatic read_word(output logic [31:0] w);
        @(negedge clk);
        w[15:0] = rd_data;
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        w[31:16] = rd_data;
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic prog(input int idx, input logic [7:0] v);
        @(negedge clk);
        lbl_we = 1'b1; lbl_idx = 4'(idx); lbl_val = v;
        @(negedge clk);
        lbl_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] got;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset flags
        check("R10 ready", {31'b0, data_ready}, 32'd0);
        check("R10 half", {31'b0, fifo_half}, 32'd0);
        check("R10 full", {31'b0, fifo_full}, 32'd0);

        // R5 empty table after reset rejects everything
        filt_en = 1'b1;
        send_word(32'h0000_0000, 32, FAST);
        check("R5 empty table", {31'b0, data_ready}, 32'd0);

        prog(0, 8'h31);
        prog(5, 8'hA7);
        prog(15, 8'h02);

        // Vector table: R1 R5 R6
        for (int v = 0; v < NV; v++) begin
            par_mode = VEC[v][33];
            send_word(VEC[v][31:0], 32, FAST);
            if (VEC[v][32]) begin
                check("R5 accepted ready", {31'b0, data_ready}, 32'd1);
                read_word(got);
                check("R1 R6 word", got, expect_word(VEC[v][31:0], VEC[v][33]));
            end else begin
                check("R5 rejected", {31'b0, data_ready}, 32'd0);
            end
        end
        par_mode = 1'b0;
        filt_en = 1'b0;

        // R2 short and long bursts discarded
        send_word(32'h1111_1111, 31, FAST);
        check("R2 31 bits", {31'b0, data_ready}, 32'd0);
        send_word(32'h2222_2222, 33, FAST);
        check("R2 33 bits", {31'b0, data_ready}, 32'd0);

        // R3 restart after a long gap inside a word
        send_bits(32'h0000_03FF, 10, FAST);
        repeat (2*FAST) @(negedge clk);
        send_word(32'hCAFE_F00D, 32, FAST);
        read_word(got);
        check("R3 restart word", got, 32'hCAFE_F00D);

        // R4 slow rate
        rate_sel = 1'b1;
        send_word(32'h5A5A_C3C3, 32, SLOW);
        check("R4 slow ready", {31'b0, data_ready}, 32'd1);
        read_word(got);
        check("R4 slow word", got, 32'h5A5A_C3C3);
        rate_sel = 1'b0;

        // R7 strobe while empty ignored; R8 ready stays after low half
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
        send_word(32'h9876_5432, 32, FAST);
        check("R7 low half after empty strobe", {16'b0, rd_data}, 32'h0000_5432);
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
        check("R8 ready after low half", {31'b0, data_ready}, 32'd1);
        check("R7 high half", {16'b0, rd_data}, 32'h0000_9876);
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
        check("R8 ready falls", {31'b0, data_ready}, 32'd0);

        // R8 R9 fill, overflow, order
        for (int i = 0; i < 33; i++) begin
            send_word(32'hA500_0000 | i, 32, FAST);
            if (i == 14) check("R8 half at 15", {31'b0, fifo_half}, 32'd0);
            if (i == 15) check("R8 half at 16", {31'b0, fifo_half}, 32'd1);
            if (i == 30) check("R8 full at 31", {31'b0, fifo_full}, 32'd0);
            if (i == 31) check("R8 full at 32", {31'b0, fifo_full}, 32'd1);
        end
        check("R9 still full", {31'b0, fifo_full}, 32'd1);
        for (int i = 0; i < 32; i++) begin
            read_word(got);
            check("R9 R7 order", got, 32'hA500_0000 | i);
        end
        check("R9 overflow dropped", {31'b0, data_ready}, 32'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule